// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level page table from memory. A request carries the linear address and three qualifiers: whether the access is a write, whether it comes from the least privileged level, and whether it is a debug probe. The control inputs come from the owning processor's control registers. They are the paging enable, the frame number of the page directory, the large-page enable and the write-protect switch. The walker samples all of them when it accepts a request.

The walker uses a simple single-outstanding memory master to fetch directory and table entries. After a walk that succeeds, it writes the accessed and dirty marks back into those entries. It finishes every request with a one-cycle `done` strobe. At that strobe it presents either the physical address or a fault with a three-bit page-fault code. It serves one request at a time, and `req_valid` is ignored while a walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: With paging disabled at acceptance, `phys_addr` equals the linear address, `fault` is 0, and the memory port stays idle for the whole request.
- R2: The directory entry is read at `{ctl_dir_frame, lin[31:22], 2'b00}`. The table entry is read at `{dir_entry[31:12], lin[21:12], 2'b00}`. A 4 KB result is `{table_entry[31:12], lin[11:0]}`.
- R3: A directory entry with bit 7 set, while the large-page enable is 1, gives `{dir_entry[31:22], lin[21:0]}`, and no table read takes place. With the enable at 0, bit 7 is ignored and a normal two-level walk follows.
- R4: A directory or table entry with bit 0 (present) clear faults with code bit 0 = 0. No write-back follows.
- R5: Protection is checked on the final entry only: the large directory entry, or the table entry. Bit 1 is writable and bit 2 is user. A user read faults without bit 2. A write faults when bit 1 is 0 and write-protect is 1, and a user write faults unless bits 1 and 2 are both set.
- R6: On a successful walk, a final entry is written back as follows. If the access is a write and bit 6 (dirty) is clear, it gets bits 6 and 5 set. Otherwise, if bit 5 (accessed) is clear, it gets bit 5 set. Otherwise it is not written.
- R7: On a successful 4 KB walk, the directory entry gets only bit 5 set, and only if that bit was clear. Its write precedes the table entry's write.
- R8: A debug request walks and faults like any other but never writes memory.
- R9: The fault code is {bit 2 = user request, bit 1 = write request, bit 0 = present but denied}. It is 0 when there is no fault.
- R10: Each accepted request yields exactly one `done` pulse of one cycle. `req_valid` is ignored from acceptance until `done` has been raised.
- R11: Each memory access holds `mem_req`, `mem_we` and `mem_addr` steady until the cycle `mem_ack` is seen, and completes in that cycle.
- R12: After reset, `done`, `fault` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | New translation request (taken when idle) |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from the least privileged level |
| req_debug | input | 1 | Probe: walk without write-back |
| ctl_pg_en | input | 1 | Paging enable |
| ctl_dir_frame | input | 20 | Page directory frame number |
| ctl_large_en | input | 1 | Large-page enable |
| ctl_wp | input | 1 | Write-protect also applies to supervisor writes |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| done | output | 1 | One-cycle completion strobe |
| phys_addr | output | 32 | Translated address, valid at `done` without fault |
| fault | output | 1 | Translation faulted, valid at `done` |
| fault_code | output | 3 | Page-fault code, valid at `done` |

## Verification
The walk geometry is fixed, with ten index bits per level and 4 KB frames, so the bench uses the only build the block has. The bench memory decodes just two pages: the directory page at frame 1 and the table page at frame 2. This lets every directory and table index be reached at little cost, and any stray address reads back a non-present zero. Within that space the bench sweeps all 32 combinations of the present, writable, user, accessed and dirty bits against every mix of write, user and debug, with write-protect both off and on. It repeats the sweep for 4 KB walks, for large pages, and for a large-page bit that has been disabled. It also covers a non-present or already-accessed directory and requests that arrive while a walk is in progress.

// File: rtl/pw_pkg.sv
// Package pw_pkg
// Purpose : shared geometry, entry bit positions, state encoding and the
//           write-back rule for page walk entries.
// Assumes : 32-bit linear and physical addresses, 4 KB frames, 4-byte entries.
package pw_pkg;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned IDX_W   = 10;
    localparam int unsigned FRAME_W = ADDR_W - OFF_W;
    localparam int unsigned BIG_LSB = OFF_W + IDX_W;

    localparam int unsigned EB_PRESENT = 0;
    localparam int unsigned EB_WRITE   = 1;
    localparam int unsigned EB_USER    = 2;
    localparam int unsigned EB_ACC     = 5;
    localparam int unsigned EB_DIRTY   = 6;
    localparam int unsigned EB_LARGE   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_WR_DIR,
        ST_WR_TBL,
        ST_FIN
    } pw_state_e;

    // True when the entry must be rewritten for this access kind.
    function automatic logic ent_needs_wb(input logic [ADDR_W-1:0] e, input logic wr);
        return (wr && !e[EB_DIRTY]) || !e[EB_ACC];
    endfunction

    // Entry value after marking: dirty+accessed on a clean write, else accessed.
    function automatic logic [ADDR_W-1:0] ent_wb_value(input logic [ADDR_W-1:0] e, input logic wr);
        logic [ADDR_W-1:0] v;
        v = e;
        v[EB_ACC] = 1'b1;
        if (wr) v[EB_DIRTY] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/pw_addr_gen.sv
// Module pw_addr_gen
// Purpose : forms the entry fetch addresses and both result address shapes.
// Assumes : frames are page-aligned; entries are 4 bytes wide.
module pw_addr_gen
    import pw_pkg::*;
(
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [ADDR_W-1:0]  lin,
    input  logic [FRAME_W-1:0] tbl_frame,
    input  logic [FRAME_W-1:0] leaf_frame,
    output logic [ADDR_W-1:0]  dir_addr,
    output logic [ADDR_W-1:0]  tbl_addr,
    output logic [ADDR_W-1:0]  phys_big,
    output logic [ADDR_W-1:0]  phys_small
);
    localparam int unsigned BIG_HI_W = ADDR_W - BIG_LSB;

    // Combine frames and index fields into byte addresses.
    always_comb begin
        dir_addr   = {dir_frame, lin[ADDR_W-1:BIG_LSB], 2'b00};
        tbl_addr   = {tbl_frame, lin[BIG_LSB-1:OFF_W], 2'b00};
        phys_big   = {leaf_frame[FRAME_W-1:FRAME_W-BIG_HI_W], lin[BIG_LSB-1:0]};
        phys_small = {leaf_frame, lin[OFF_W-1:0]};
    end
endmodule

// File: rtl/pw_entry_check.sv
// Module pw_entry_check
// Purpose : presence and protection verdict for one entry.
// Assumes : flags are entry bits {user, writable, present}.
module pw_entry_check (
    input  logic [2:0] flags,
    input  logic       wr,
    input  logic       usr,
    input  logic       wp,
    output logic       present,
    output logic       denied
);
    logic wr_ok, usr_wr_ok;

    // Apply the read/write/user permission rules.
    always_comb begin
        present   = flags[0];
        wr_ok     = flags[1] | ~wp;
        usr_wr_ok = flags[1] & flags[2];
        if (wr) denied = ~wr_ok | (usr & ~usr_wr_ok);
        else    denied = usr & ~flags[2];
    end
endmodule

// File: rtl/pt_walker.sv
// Module pt_walker
// Purpose : two-level page table walk with large pages, accessed/dirty
//           write-back and page-fault code generation.
// Assumes : one request at a time; memory port keeps one access outstanding
//           and signals completion with mem_ack; rdata valid with mem_ack.
module pt_walker
    import pw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_lin,
    input  logic               req_write,
    input  logic               req_user,
    input  logic               req_debug,
    input  logic               ctl_pg_en,
    input  logic [FRAME_W-1:0] ctl_dir_frame,
    input  logic               ctl_large_en,
    input  logic               ctl_wp,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ADDR_W-1:0]  mem_wdata,
    input  logic [ADDR_W-1:0]  mem_rdata,
    input  logic               mem_ack,
    output logic               done,
    output logic [ADDR_W-1:0]  phys_addr,
    output logic               fault,
    output logic [2:0]         fault_code
);
    pw_state_e          state;
    logic [ADDR_W-1:0]  lin_q, dir_q, tbl_q, phys_q;
    logic [FRAME_W-1:0] base_q;
    logic               wr_q, usr_q, dbg_q, pg_q, lpe_q, wp_q, big_q;
    logic               fault_q;
    logic [2:0]         code_q;

    logic [ADDR_W-1:0]  dir_addr, tbl_addr, phys_big, phys_small;
    logic               ent_present, ent_denied;

    pw_addr_gen u_addr (
        .dir_frame  (base_q),
        .lin        (lin_q),
        .tbl_frame  (dir_q[ADDR_W-1:OFF_W]),
        .leaf_frame (mem_rdata[ADDR_W-1:OFF_W]),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr),
        .phys_big   (phys_big),
        .phys_small (phys_small)
    );

    pw_entry_check u_chk (
        .flags   (mem_rdata[EB_USER:EB_PRESENT]),
        .wr      (wr_q),
        .usr     (usr_q),
        .wp      (wp_q),
        .present (ent_present),
        .denied  (ent_denied)
    );

    // Walk sequencer: accept, fetch, judge, write back, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lin_q   <= '0;
            base_q  <= '0;
            dir_q   <= '0;
            tbl_q   <= '0;
            phys_q  <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            dbg_q   <= 1'b0;
            pg_q    <= 1'b0;
            lpe_q   <= 1'b0;
            wp_q    <= 1'b0;
            big_q   <= 1'b0;
            fault_q <= 1'b0;
            code_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    lin_q   <= req_lin;
                    base_q  <= ctl_dir_frame;
                    wr_q    <= req_write;
                    usr_q   <= req_user;
                    dbg_q   <= req_debug;
                    pg_q    <= ctl_pg_en;
                    lpe_q   <= ctl_large_en;
                    wp_q    <= ctl_wp;
                    big_q   <= 1'b0;
                    fault_q <= 1'b0;
                    code_q  <= '0;
                    phys_q  <= req_lin;
                    state   <= ctl_pg_en ? ST_RD_DIR : ST_FIN;
                end
                ST_RD_DIR: if (mem_ack) begin
                    dir_q <= mem_rdata;
                    if (!ent_present) begin
                        fault_q <= 1'b1;
                        code_q  <= {usr_q, wr_q, 1'b0};
                        state   <= ST_FIN;
                    end else if (mem_rdata[EB_LARGE] && lpe_q) begin
                        big_q <= 1'b1;
                        if (ent_denied) begin
                            fault_q <= 1'b1;
                            code_q  <= {usr_q, wr_q, 1'b1};
                            state   <= ST_FIN;
                        end else begin
                            phys_q <= phys_big;
                            state  <= (!dbg_q && ent_needs_wb(mem_rdata, wr_q)) ? ST_WR_DIR : ST_FIN;
                        end
                    end else begin
                        state <= ST_RD_TBL;
                    end
                end
                ST_RD_TBL: if (mem_ack) begin
                    tbl_q <= mem_rdata;
                    if (!ent_present || ent_denied) begin
                        fault_q <= 1'b1;
                        code_q  <= {usr_q, wr_q, ent_present};
                        state   <= ST_FIN;
                    end else begin
                        phys_q <= phys_small;
                        if (!dbg_q && !dir_q[EB_ACC])
                            state <= ST_WR_DIR;
                        else if (!dbg_q && ent_needs_wb(mem_rdata, wr_q))
                            state <= ST_WR_TBL;
                        else
                            state <= ST_FIN;
                    end
                end
                ST_WR_DIR: if (mem_ack) begin
                    state <= (!big_q && ent_needs_wb(tbl_q, wr_q)) ? ST_WR_TBL : ST_FIN;
                end
                ST_WR_TBL: if (mem_ack) begin
                    state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory master drive, decoded from the walk state.
    always_comb begin
        mem_req   = (state == ST_RD_DIR) || (state == ST_RD_TBL) ||
                    (state == ST_WR_DIR) || (state == ST_WR_TBL);
        mem_we    = (state == ST_WR_DIR) || (state == ST_WR_TBL);
        mem_addr  = ((state == ST_RD_DIR) || (state == ST_WR_DIR)) ? dir_addr : tbl_addr;
        mem_wdata = '0;
        if (state == ST_WR_DIR) mem_wdata = ent_wb_value(dir_q, wr_q & big_q);
        if (state == ST_WR_TBL) mem_wdata = ent_wb_value(tbl_q, wr_q);
    end

    // Result outputs.
    always_comb begin
        done       = (state == ST_FIN);
        phys_addr  = phys_q;
        fault      = fault_q;
        fault_code = code_q;
    end
endmodule

// File: rtl/pw_checker.sv
// Module pw_checker
// Purpose : temporal checks on the walker's ports and sampled request state.
// Assumes : bound to pt_walker; reset is synchronous and active low.
module pw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        fault,
    input logic [2:0]  fault_code,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        dbg_q,
    input logic        pg_q
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_UNPAGED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> pg_q); // R1
    AST_DEBUG_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !dbg_q); // R8
    AST_WB_MARKS_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[5]); // R6
    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
    AST_DENY_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code[0]) |-> fault); // R9
endmodule

bind pt_walker pw_checker u_pw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .dbg_q      (dbg_q),
    .pg_q       (pg_q)
);

// File: tb/tb_pt_walker.sv
// Bench for pt_walker: sweeps entry flags against access kinds over a
// two-page memory (directory at frame 1, table at frame 2).
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0, req_user = 1'b0, req_debug = 1'b0;
    logic        ctl_pg_en = 1'b0, ctl_large_en = 1'b0, ctl_wp = 1'b0;
    logic [19:0] ctl_dir_frame = 20'h00001;
    logic        mem_req, mem_we, mem_ack, done, fault;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, phys_addr;
    logic [2:0]  fault_code;

    always #10 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user), .req_debug(req_debug),
        .ctl_pg_en(ctl_pg_en), .ctl_dir_frame(ctl_dir_frame),
        .ctl_large_en(ctl_large_en), .ctl_wp(ctl_wp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .done(done), .phys_addr(phys_addr), .fault(fault), .fault_code(fault_code)
    );

    // Memory model: 4096 words decoded from address bits 13:2, one-cycle ack.
    logic [31:0] mem [0:4095];
    logic        pl_en = 1'b0;
    logic [11:0] pl_idx = '0;
    logic [31:0] pl_dat = '0;
    int          n_acc = 0, n_reqcyc = 0, n_done = 0;
    logic        ack_r = 1'b0;
    logic [31:0] rdata_r = '0;
    assign mem_ack   = ack_r;
    assign mem_rdata = rdata_r;

    initial for (int i = 0; i < 4096; i++) mem[i] = '0;

    always @(posedge clk) begin
        if (pl_en) mem[pl_idx] <= pl_dat;
        if (!rst_n) begin
            ack_r <= 1'b0;
        end else begin
            ack_r <= mem_req && !ack_r;
            if (mem_req && !ack_r) begin
                rdata_r <= mem[mem_addr[13:2]];
                if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            end
            if (mem_req) n_reqcyc <= n_reqcyc + 1;
            if (mem_req && ack_r) n_acc <= n_acc + 1;
            if (done) n_done <= n_done + 1;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit hung = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [11:0] idx, input logic [31:0] dat);
        @(negedge clk);
        pl_en = 1'b1; pl_idx = idx; pl_dat = dat;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    function automatic logic [31:0] flags2ent(input logic [4:0] f);
        logic [31:0] e;
        e = '0;
        e[0] = f[0]; e[1] = f[1]; e[2] = f[2]; e[5] = f[3]; e[6] = f[4];
        return e;
    endfunction

    // R6 rule: clean write gets dirty+accessed, else accessed if missing.
    function automatic logic [31:0] marked(input logic [31:0] e, input bit w);
        if (w && !e[6]) return e | 32'h60;
        if (!e[5])      return e | 32'h20;
        return e;
    endfunction

    // R5 rule.
    function automatic bit blocked(input logic [31:0] e, input bit w, input bit u, input bit wp);
        if (w) begin
            if (!e[1] && wp) return 1'b1;
            if (u && !(e[1] && e[2])) return 1'b1;
            return 1'b0;
        end
        return u && !e[2];
    endfunction

    task automatic run_vec(input logic [31:0] lin, input bit w, input bit u, input bit dbg,
                           input bit pg, input bit lpe, input bit wp,
                           input logic [31:0] dent, input logic [31:0] tent, input bit intrude);
        logic [11:0] didx, tidx;
        logic [31:0] e_phys, e_d, e_t;
        bit          e_fault, big;
        logic [2:0]  e_code;
        int          e_acc, a0, r0, d0, wd;
        if (hung) return;
        didx = {2'd1, lin[31:22]};
        tidx = {2'd2, lin[21:12]};
        preload(didx, dent);
        preload(tidx, tent);
        e_phys = lin; e_fault = 1'b0; e_code = 3'd0; e_d = dent; e_t = tent; e_acc = 0;
        big = dent[7] && lpe;
        if (pg) begin
            if (!dent[0]) begin
                e_fault = 1'b1; e_code = {u, w, 1'b0}; e_acc = 1;
            end else if (big) begin
                e_acc = 1;
                if (blocked(dent, w, u, wp)) begin
                    e_fault = 1'b1; e_code = {u, w, 1'b1};
                end else begin
                    e_phys = {dent[31:22], lin[21:0]};
                    if (!dbg && marked(dent, w) != dent) begin e_d = marked(dent, w); e_acc = 2; end
                end
            end else begin
                e_acc = 2;
                if (!tent[0]) begin
                    e_fault = 1'b1; e_code = {u, w, 1'b0};
                end else if (blocked(tent, w, u, wp)) begin
                    e_fault = 1'b1; e_code = {u, w, 1'b1};
                end else begin
                    e_phys = {tent[31:12], lin[11:0]};
                    if (!dbg) begin
                        if (!dent[5]) begin e_d = dent | 32'h20; e_acc++; end
                        if (marked(tent, w) != tent) begin e_t = marked(tent, w); e_acc++; end
                    end
                end
            end
        end
        a0 = n_acc; r0 = n_reqcyc; d0 = n_done;
        @(negedge clk);
        req_valid = 1'b1; req_lin = lin; req_write = w; req_user = u; req_debug = dbg;
        ctl_pg_en = pg; ctl_large_en = lpe; ctl_wp = wp;
        @(negedge clk);
        if (intrude) begin
            // R10: a second request during the walk must be ignored
            req_lin = ~lin; req_write = ~w;
            @(negedge clk);
        end
        req_valid = 1'b0;
        wd = 0;
        while (!done && wd < 100) begin @(negedge clk); wd++; end
        if (!done) begin
            hung = 1'b1; n_chk++; n_bad++;
            $display("FAIL R10: watchdog, actual no done expected done");
            return;
        end
        chk(pg ? "R4 R5 R9 fault" : "R1 fault", {31'd0, fault}, {31'd0, e_fault});
        chk("R9 fault code", {29'd0, fault_code}, {29'd0, e_code});
        if (!e_fault) chk(!pg ? "R1 phys" : (big ? "R3 phys" : "R2 phys"), phys_addr, e_phys);
        repeat (3) @(negedge clk);
        chk("R10 done pulses", n_done - d0, 1);
        chk(dbg ? "R8 access count" : "R2 R3 R7 access count", n_acc - a0, e_acc);
        chk("R11 request cycles", n_reqcyc - r0, 2 * (n_acc - a0));
        chk(dbg ? "R8 dir entry" : "R6 R7 dir entry", mem[didx], e_d);
        chk(dbg ? "R8 table entry" : "R6 R7 table entry", mem[tidx], e_t);
        preload(didx, 32'd0);
        preload(tidx, 32'd0);
    endtask

    initial begin
        int v;
        v = 0;
        repeat (3) @(negedge clk);
        // R12: quiet after reset
        chk("R12 done", {31'd0, done}, 32'd0);
        chk("R12 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R12 fault", {31'd0, fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: paging off, memory holds live entries that must not be touched
        for (int k = 0; k < 8; k++)
            run_vec(32'h1357_9BDF * (k + 1), k[0], k[1], k[2], 1'b0, 1'b1, 1'b1,
                    32'h0000_2067, 32'h0000_5007, 1'b0);
        // R2 R4 R5 R6 R7 R8: 4 KB walks, directory present/absent/accessed
        for (int mode = 0; mode < 4; mode++)
            for (int f = 0; f < 32; f++)
                for (int acc = 0; acc < 8; acc++)
                    for (int wp = 0; wp < 2; wp++) begin
                        logic [31:0] lin, dent, tent;
                        v++;
                        lin  = {10'(v * 37 + 3), 10'(v * 53 + 11), 12'(v * 97)};
                        tent = {20'(v * 7 + 32'h12345), 12'd0} | flags2ent(5'(f));
                        case (mode)
                            0: dent = 32'h0000_2003;              // present, not accessed
                            1: dent = 32'h0000_2027;              // present, accessed
                            2: dent = 32'h0000_2006;              // R4 absent directory
                            default: dent = 32'h0000_2083;        // R3 large bit, enable off
                        endcase
                        run_vec(lin, acc[0], acc[1], acc[2], 1'b1, mode == 3 ? 1'b0 : 1'b1,
                                wp[0], dent, tent, (v % 5) == 0);
                    end
        // R3 R5 R6 R8: large pages with every flag mix
        for (int f = 0; f < 32; f++)
            for (int acc = 0; acc < 8; acc++)
                for (int wp = 0; wp < 2; wp++) begin
                    logic [31:0] lin, dent;
                    v++;
                    lin  = {10'(v * 41 + 5), 10'(v * 29 + 7), 12'(v * 83)};
                    dent = {10'(v * 13 + 9), 22'h00_0080} | flags2ent(5'(f));
                    run_vec(lin, acc[0], acc[1], acc[2], 1'b1, 1'b1, wp[0], dent,
                            32'h0000_9007, (v % 7) == 0);
                end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule